// File: doc/BRIEF.md
# Word/Byte Switchable Static Memory

This block is a functional model of a static RAM whose data organization is picked at run time by a mode input. In word mode each address selects a 16-bit word, and two active-low lane controls gate the low and the high byte of the bus separately. In byte mode an extra low-order address input joins the word address to select one 8-bit byte, and all byte traffic uses the low lane of the bus. Both modes address the same storage. The even byte of a word sits in its low lane and the odd byte sits in its high lane, so data written in one mode reads back correctly in the other.

The bidirectional bus is split into an input vector, an output vector and a per-lane drive enable. A lane whose enable is low represents high impedance and shows zeros on its output bits. The chip responds only when its active-low enable is low and its active-high enable is high. A write is sampled on the rising edge of the model clock. Read data is combinational from the current inputs.

Top module: `wbsw_sram`

## Requirements
- R1: The chip is selected only when `cs_n` is 0 and `cs` is 1. Otherwise `dout_en` is 2'b00 and no storage changes.
- R2: In word mode (`word_mode`=1) with `lo_n` and `hi_n` both 1, the chip acts deselected: no lane is driven and nothing is written.
- R3: In word mode the word index is `addr`, and `addr_lsb` has no effect on reads or writes.
- R4: In byte mode (`word_mode`=0) the byte address is {`addr`,`addr_lsb`}. Byte {a,0} is bits 7:0 of word a and byte {a,1} is bits 15:8 of word a.
- R5: In byte mode a write takes its data from `din[7:0]`, a read returns it on `dout[7:0]` with `dout_en`=2'b01, and `lo_n`/`hi_n` have no effect.
- R6: In word mode `lo_n`=0 enables lane 0 (bits 7:0) and `hi_n`=0 enables lane 1 (bits 15:8), for both reads and writes. `dout_en[i]` is the drive enable of lane i.
- R7: When the chip is selected and `we_n`=0, the enabled lanes are written at the rising clock edge. `oe_n` is ignored and `dout_en` is 2'b00.
- R8: A read drives its lanes only when the chip is selected, `we_n`=1 and `oe_n`=0. With `oe_n`=1, `dout_en` is 2'b00.
- R9: Output bits of a lane whose drive enable is 0 read as 0.
- R10: While `rst` is 1, no write takes effect and `dout_en` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock; writes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes and output drive |
| word_mode | input | 1 | 1 = 16-bit word organization, 0 = 8-bit byte organization |
| addr | input | WORD_AW | Word address |
| addr_lsb | input | 1 | Byte select below `addr`, used in byte mode only |
| cs_n | input | 1 | Chip enable, active low |
| cs | input | 1 | Chip enable, active high |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| lo_n | input | 1 | Low-lane control, active low (word mode) |
| hi_n | input | 1 | High-lane control, active low (word mode) |
| din | input | 16 | Bus data into the memory |
| dout | output | 16 | Bus data out of the memory |
| dout_en | output | 2 | Per-lane drive enable; 0 stands for high impedance |

## Verification
The bench builds the block with its default `WORD_AW` of 6, which gives 64 words. With that size both the lowest and the highest word (63) are within reach, so byte addressing is exercised at the top of the range, where {63,1} is the last byte. Words written in one mode are read back in the other. Attempts that must be refused are each followed by a read of the same word: deselection by either chip enable, both lanes off, and reset.

// File: rtl/wbsw_sram_pkg.sv
package wbsw_sram_pkg;
  localparam int LANE_W = 8;
  localparam int LANES  = 2;
  localparam int BUS_W  = LANE_W * LANES;
  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [LANES-1:0]  lane_mask_t;
endpackage

// File: rtl/wbsw_sram_ctl.sv
module wbsw_sram_ctl
  import wbsw_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       word_mode,
  input  logic       addr_lsb,
  input  logic       cs_n,
  input  logic       cs,
  input  logic       we_n,
  input  logic       oe_n,
  input  logic       lo_n,
  input  logic       hi_n,
  output lane_mask_t wr_lane,
  output lane_mask_t drv_lane,
  output logic       pick_hi
);
  logic       chip_on;
  logic       active;
  lane_mask_t lane_req;

  always_comb begin
    chip_on  = !cs_n && cs && !rst;
    // word mode: lanes from the controls; byte mode: lane from the byte select
    lane_req = word_mode ? {!hi_n, !lo_n} : (addr_lsb ? 2'b10 : 2'b01);
    active   = chip_on && (|lane_req);
    wr_lane  = (active && !we_n) ? lane_req : '0;
    if (active && we_n && !oe_n)
      drv_lane = word_mode ? lane_req : 2'b01;
    else
      drv_lane = '0;
    pick_hi  = !word_mode && addr_lsb;
  end

  p_desel_r1: assert property (@(posedge clk) disable iff (rst)
    (cs_n || !cs) |-> (wr_lane == '0 && drv_lane == '0));
  p_both_off_r2: assert property (@(posedge clk) disable iff (rst)
    (word_mode && lo_n && hi_n) |-> (wr_lane == '0 && drv_lane == '0));
  p_byte_lane0_r5: assert property (@(posedge clk) disable iff (rst)
    !word_mode |-> (!drv_lane[1] && $onehot0(wr_lane)));
  p_write_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> (drv_lane == '0));
  p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
    oe_n |-> (drv_lane == '0));
endmodule

// File: rtl/wbsw_sram_lane.sv
module wbsw_sram_lane #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  p_store_r7: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/wbsw_sram_rdmux.sv
module wbsw_sram_rdmux
  import wbsw_sram_pkg::*;
(
  input  lane_t             lane_lo,
  input  lane_t             lane_hi,
  input  lane_mask_t        drv_lane,
  input  logic              pick_hi,
  output logic [BUS_W-1:0]  dout,
  output lane_mask_t        dout_en
);
  always_comb begin
    dout[LANE_W-1:0]     = drv_lane[0] ? (pick_hi ? lane_hi : lane_lo) : '0;
    dout[BUS_W-1:LANE_W] = drv_lane[1] ? lane_hi : '0;
    dout_en              = drv_lane;
  end
endmodule

// File: rtl/wbsw_sram.sv
module wbsw_sram
  import wbsw_sram_pkg::*;
#(
  parameter int WORD_AW = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               word_mode,
  input  logic [WORD_AW-1:0] addr,
  input  logic               addr_lsb,
  input  logic               cs_n,
  input  logic               cs,
  input  logic               we_n,
  input  logic               oe_n,
  input  logic               lo_n,
  input  logic               hi_n,
  input  logic [15:0]        din,
  output logic [15:0]        dout,
  output logic [1:0]         dout_en
);
  lane_mask_t wr_lane;
  lane_mask_t drv_lane;
  logic       pick_hi;
  lane_t      rd_lane [LANES];

  wbsw_sram_ctl u_ctl (
    .clk(clk), .rst(rst), .word_mode(word_mode), .addr_lsb(addr_lsb),
    .cs_n(cs_n), .cs(cs), .we_n(we_n), .oe_n(oe_n), .lo_n(lo_n), .hi_n(hi_n),
    .wr_lane(wr_lane), .drv_lane(drv_lane), .pick_hi(pick_hi)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    lane_t wd;
    // byte mode feeds every lane from the low bus lane
    assign wd = word_mode ? din[g*LANE_W +: LANE_W] : din[LANE_W-1:0];
    wbsw_sram_lane #(.AW(WORD_AW), .W(LANE_W)) u_mem (
      .clk(clk), .rst(rst), .we(wr_lane[g]), .addr(addr),
      .wdata(wd), .rdata(rd_lane[g])
    );
  end

  wbsw_sram_rdmux u_rdmux (
    .lane_lo(rd_lane[0]), .lane_hi(rd_lane[1]), .drv_lane(drv_lane),
    .pick_hi(pick_hi), .dout(dout), .dout_en(dout_en)
  );

  always_comb begin
    if (rst) p_reset_quiet_r10: assert (dout_en == 2'b00);
  end

  p_lane_idle_r9: assert property (@(posedge clk) disable iff (rst)
    (!dout_en[1] |-> dout[15:8] == 8'h00) and (!dout_en[0] |-> dout[7:0] == 8'h00));
endmodule

// File: tb/tb_wbsw_sram.sv
module tb_wbsw_sram;
  typedef struct packed {
    logic        wm;
    logic [5:0]  a;
    logic        lsb;
    logic        csn;
    logic        cs;
    logic        wen;
    logic        oen;
    logic        lon;
    logic        hin;
    logic [15:0] d;
    logic [15:0] xd;
    logic [1:0]  xe;
    logic [3:0]  req;
  } vec_t;

  localparam int N = 22;
  // fields: wm a lsb cs_n cs we_n oe_n lo_n hi_n din exp_dout exp_en req
  localparam vec_t TBL [N] = '{
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA1B2, 16'h0000, 2'b00, 4'd7}, // R7 write, oe ignored
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hA1B2, 2'b11, 4'd6}, // R6 both lanes
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 16'h0000, 16'h00B2, 2'b01, 4'd6}, // R6 low only
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'hA100, 2'b10, 4'd9}, // R9 idle lane zero
    '{1'b0, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h00B2, 2'b01, 4'd4}, // R4 even byte
    '{1'b0, 6'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 16'h0000, 16'h00A1, 2'b01, 4'd4}, // R4 odd byte
    '{1'b0, 6'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'h5C7E, 16'h0000, 2'b00, 4'd5}, // R5 byte write, controls high
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h7EB2, 2'b11, 4'd4}, // R4 odd byte in high lane
    '{1'b0, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h0033, 16'h0000, 2'b00, 4'd5}, // R5 even byte write
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h7E33, 2'b11, 4'd5}, // R5 readback
    '{1'b1, 6'd3,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'b00, 4'd1}, // R1 cs_n high
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'hFFFF, 16'h0000, 2'b00, 4'd1}, // R1 cs low
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 16'hFFFF, 16'h0000, 2'b00, 4'd2}, // R2 both lanes off
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h7E33, 2'b11, 4'd1}, // R1 R2 nothing landed
    '{1'b1, 6'd3,  1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 16'h1234, 16'h0000, 2'b00, 4'd3}, // R3 lsb set, high lane
    '{1'b1, 6'd3,  1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h1233, 2'b11, 4'd3}, // R3 same word
    '{1'b1, 6'd3,  1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b00, 4'd8}, // R8 oe_n high
    '{1'b0, 6'd3,  1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h0000, 2'b00, 4'd1}, // R1 byte mode deselect
    '{1'b1, 6'd63, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hBEEF, 16'h0000, 2'b00, 4'd7}, // R7 top word
    '{1'b1, 6'd63, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'hBEEF, 2'b11, 4'd8}, // R8 read
    '{1'b0, 6'd63, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000, 16'h00BE, 2'b01, 4'd4}, // R4 last byte
    '{1'b0, 6'd63, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000, 16'h00EF, 2'b01, 4'd5}  // R5 controls ignored
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b1;
  logic [5:0]  addr = '0;
  logic        addr_lsb = 1'b0;
  logic        cs_n = 1'b1;
  logic        cs = 1'b0;
  logic        we_n = 1'b1;
  logic        oe_n = 1'b1;
  logic        lo_n = 1'b1;
  logic        hi_n = 1'b1;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic [1:0]  dout_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  wbsw_sram #(.WORD_AW(6)) dut (
    .clk(clk), .rst(rst), .word_mode(word_mode), .addr(addr), .addr_lsb(addr_lsb),
    .cs_n(cs_n), .cs(cs), .we_n(we_n), .oe_n(oe_n), .lo_n(lo_n), .hi_n(hi_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  task automatic apply(input vec_t v);
    word_mode = v.wm; addr = v.a; addr_lsb = v.lsb; cs_n = v.csn; cs = v.cs;
    we_n = v.wen; oe_n = v.oen; lo_n = v.lon; hi_n = v.hin; din = v.d;
  endtask

  task automatic check(input string tag, input logic [15:0] xd, input logic [1:0] xe);
    checks++;
    if (dout !== xd || dout_en !== xe) begin
      fails++;
      $display("FAIL %s: dout=%h en=%b expected dout=%h en=%b", tag, dout, dout_en, xd, xe);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10 reset state with a read request present
    @(negedge clk);
    apply('{1'b1, 6'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 2'b00, 4'd10});
    #2 check("R10 reset outputs", 16'h0000, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      apply(TBL[i]);
      #2 check($sformatf("R%0d vector %0d", TBL[i].req, i), TBL[i].xd, TBL[i].xe);
    end
    // R10 write refused under reset
    @(negedge clk);
    apply('{1'b1, 6'd10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'h1111, 16'h0, 2'b00, 4'd10});
    @(negedge clk);
    rst = 1'b1;
    din = 16'h2222;
    #2 check("R10 outputs off in reset during write", 16'h0000, 2'b00);
    @(negedge clk);
    rst = 1'b0;
    apply('{1'b1, 6'd10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 2'b00, 4'd10});
    #2 check("R10 write under reset dropped", 16'h1111, 2'b11);
    // R3 read with addr_lsb set in word mode sees the same word
    @(negedge clk);
    addr_lsb = 1'b1;
    #2 check("R3 lsb ignored on read", 16'h1111, 2'b11);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule